// File: doc/BRIEF.md
# Clock-Generator Watchdog with Safe-Frequency Fallback

This block guards the frequency setting of a clock generator. Once it is armed, it counts slow ticks against a programmable timeout. If the timeout runs out before software restarts it, the block sets sticky alarm status and replaces the frequency code it presents with a safe code. When hard alarms are enabled it also drives an active-low system reset for a fixed number of ticks. The safe code is taken either from a programmed register field or from the strap code latched at power-up. A separate request for a frequency-ratio change produces the same reset pulse.

Software controls the block through one control byte. Writing that byte, or pulsing the kick input, reloads the count. The timeout is the 3-bit multiplier times one of two time bases. Each time base is a number of ticks, set by a parameter, and stands for about 290 ms or about 1160 ms. The PLL reprogramming and the serial register transport sit outside this block.

Top module: `fsafe_wdog`

## Requirements
- R1: After reset the control byte reads 0x07, the reset output is high and the frequency output equals the run code.
- R2: Control bit 3 selects the time base: 0 gives BASE_SHORT_TICKS and 1 gives BASE_LONG_TICKS. Bits 2:0 hold the multiplier X. The watchdog expires on the X·base-th tick after a reload, and X = 0 counts as 1.
- R3: On expiry with the soft enable (bit 6) set, soft status (bit 4) sets and the frequency output switches to the safe code, with no reset pulse.
- R4: On expiry with the hard enable (bit 7) set, hard status (bit 5) sets. The reset output then stays low for exactly RST_TICKS ticks, 16 by default, and goes high on the tick that ends the count.
- R5: With the safe-source input at 0 the safe code is the programmed 5-bit code. With it at 1 the safe code is the latched strap code.
- R6: A pulse on the kick input or any control write reloads the count from zero. Either one takes priority over an expiry in the same cycle.
- R7: Status bits and the fallback hold through kicks and further ticks until the next control write, which clears them. Bits 5:4 of a written byte are ignored.
- R8: A one-cycle frequency-ratio change request drives the reset output low for RST_TICKS ticks, whatever the enables are set to.
- R9: While both enables are clear the watchdog never expires.
- R10: The control byte reads, from bit 7 down: hard enable, soft enable, hard status, soft status, time-base select, X[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base tick |
| kick_i | input | 1 | Watchdog restart pulse |
| ctrl_wr_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_rdata_o | output | 8 | Control byte with status |
| ratio_chg_i | input | 1 | Frequency-ratio change request |
| run_code_i | input | 5 | Frequency code in normal operation |
| sf_src_i | input | 1 | Safe-code source: 0 programmed, 1 strap |
| sf_code_i | input | 5 | Programmed safe code |
| strap_code_i | input | 5 | Latched strap code |
| freq_code_o | output | 5 | Frequency code in force |
| sys_rst_n_o | output | 1 | Active-low system reset |

## Verification
A control write or kick takes effect at the clock edge that samples it. The expiring tick updates the status bits, the fallback and the reset output at that same edge, so all three can be seen in the next half cycle. The bench applies one tick per call and samples on the falling edge after each tick. It counts ticks up to the first status change and compares that count with X·base. The reset release is counted in the same way, and RST_TICKS ticks are expected after the triggering edge.

// File: rtl/fsafe_wdog_pkg.sv
package fsafe_wdog_pkg;

  localparam int CODE_W = 5;
  localparam int MULT_W = 3;

  typedef struct packed {
    logic              hard_en;
    logic              soft_en;
    logic              tbase_long;
    logic [MULT_W-1:0] mult;
  } wd_cfg_t;

  localparam wd_cfg_t CFG_RESET = '{hard_en: 1'b0, soft_en: 1'b0,
                                    tbase_long: 1'b0, mult: 3'd7};

  function automatic logic [MULT_W:0] eff_mult(input logic [MULT_W-1:0] m);
    return (m == '0) ? (MULT_W+1)'(1) : {1'b0, m};
  endfunction

  function automatic logic [7:0] pack_ctrl(input wd_cfg_t c,
                                           input logic hst, input logic sst);
    return {c.hard_en, c.soft_en, hst, sst, c.tbase_long, c.mult};
  endfunction

endpackage

// File: rtl/fsafe_wdog_regs.sv
module fsafe_wdog_regs
  import fsafe_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       expire_i,
  output wd_cfg_t    cfg_o,
  output logic       fallback_o,
  output logic [7:0] rdata_o
);

  wd_cfg_t cfg_q, cfg_d;
  logic    hst_q, hst_d;
  logic    sst_q, sst_d;
  logic    fb_q,  fb_d;
  logic    en_upd;

  assign en_upd = wr_i | expire_i;

  always_comb begin
    cfg_d = cfg_q;
    hst_d = hst_q;
    sst_d = sst_q;
    fb_d  = fb_q;
    if (wr_i) begin
      cfg_d.hard_en    = wdata_i[7];
      cfg_d.soft_en    = wdata_i[6];
      cfg_d.tbase_long = wdata_i[3];
      cfg_d.mult       = wdata_i[2:0];
      hst_d = 1'b0;
      sst_d = 1'b0;
      fb_d  = 1'b0;
    end else if (expire_i) begin
      hst_d = hst_q | cfg_q.hard_en;
      sst_d = sst_q | cfg_q.soft_en;
      fb_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      hst_q <= 1'b0;
      sst_q <= 1'b0;
      fb_q  <= 1'b0;
    end else if (en_upd) begin
      cfg_q <= cfg_d;
      hst_q <= hst_d;
      sst_q <= sst_d;
      fb_q  <= fb_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign fallback_o = fb_q;
  assign rdata_o    = pack_ctrl(cfg_q, hst_q, sst_q);

endmodule

// File: rtl/fsafe_wdog_timer.sv
module fsafe_wdog_timer
  import fsafe_wdog_pkg::*;
#(
  parameter int BASE_SHORT_TICKS = 290,
  parameter int BASE_LONG_TICKS  = 1160
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic              tbase_long_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              expire_o
);

  localparam int BMAX  = (BASE_LONG_TICKS > BASE_SHORT_TICKS) ?
                         BASE_LONG_TICKS : BASE_SHORT_TICKS;
  localparam int CNT_W = $clog2(BMAX + 1);

  logic [CNT_W-1:0]  base_lim;
  logic [CNT_W-1:0]  base_q, base_d;
  logic [MULT_W-1:0] mult_q, mult_d;
  logic              base_last, mult_last, en_cnt;

  generate
    if (BASE_SHORT_TICKS == BASE_LONG_TICKS) begin : g_one_base
      assign base_lim = CNT_W'(BASE_SHORT_TICKS - 1);
    end else begin : g_two_base
      assign base_lim = tbase_long_i ? CNT_W'(BASE_LONG_TICKS - 1)
                                     : CNT_W'(BASE_SHORT_TICKS - 1);
    end
  endgenerate

  assign base_last = (base_q == base_lim);
  assign mult_last = ({1'b0, mult_q} == (eff_mult(mult_i) - (MULT_W+1)'(1)));
  assign expire_o  = run_i & ~restart_i & tick_i & base_last & mult_last;
  assign en_cnt    = restart_i | ~run_i | tick_i;

  always_comb begin
    base_d = base_q;
    mult_d = mult_q;
    if (restart_i || !run_i) begin
      base_d = '0;
      mult_d = '0;
    end else if (tick_i) begin
      if (base_last) begin
        base_d = '0;
        mult_d = mult_last ? '0 : mult_q + MULT_W'(1);
      end else begin
        base_d = base_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mult_q <= '0;
    end else if (en_cnt) begin
      base_q <= base_d;
      mult_q <= mult_d;
    end
  end

endmodule

// File: rtl/fsafe_wdog_rstgen.sv
module fsafe_wdog_rstgen #(
  parameter int RST_TICKS = 16
)(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic trig_i,
  output logic rst_n_o
);

  localparam int PW = $clog2(RST_TICKS + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          en_cnt;

  assign en_cnt = trig_i | (tick_i & (cnt_q != '0));

  always_comb begin
    if (trig_i) cnt_d = PW'(RST_TICKS);
    else        cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (en_cnt) cnt_q <= cnt_d;
  end

  assign rst_n_o = (cnt_q == '0);

endmodule

// File: rtl/fsafe_wdog.sv
module fsafe_wdog
  import fsafe_wdog_pkg::*;
#(
  parameter int BASE_SHORT_TICKS = 290,
  parameter int BASE_LONG_TICKS  = 1160,
  parameter int RST_TICKS        = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              ctrl_wr_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  input  logic              ratio_chg_i,
  input  logic [CODE_W-1:0] run_code_i,
  input  logic              sf_src_i,
  input  logic [CODE_W-1:0] sf_code_i,
  input  logic [CODE_W-1:0] strap_code_i,
  output logic [CODE_W-1:0] freq_code_o,
  output logic              sys_rst_n_o
);

  wd_cfg_t           cfg;
  logic              fallback, expire, hard_trig;
  logic [CODE_W-1:0] safe_code;

  fsafe_wdog_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (ctrl_wr_i),
    .wdata_i   (ctrl_wdata_i),
    .expire_i  (expire),
    .cfg_o     (cfg),
    .fallback_o(fallback),
    .rdata_o   (ctrl_rdata_o)
  );

  fsafe_wdog_timer #(
    .BASE_SHORT_TICKS(BASE_SHORT_TICKS),
    .BASE_LONG_TICKS (BASE_LONG_TICKS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .restart_i   (kick_i | ctrl_wr_i),
    .run_i       (cfg.hard_en | cfg.soft_en),
    .tbase_long_i(cfg.tbase_long),
    .mult_i      (cfg.mult),
    .expire_o    (expire)
  );

  assign hard_trig = (expire & cfg.hard_en) | ratio_chg_i;

  fsafe_wdog_rstgen #(
    .RST_TICKS(RST_TICKS)
  ) u_rstgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .trig_i (hard_trig),
    .rst_n_o(sys_rst_n_o)
  );

  assign safe_code   = sf_src_i ? strap_code_i : sf_code_i;
  assign freq_code_o = fallback ? safe_code : run_code_i;

endmodule

// File: rtl/fsafe_wdog_chk.sv
module fsafe_wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       kick_i,
  input logic       ctrl_wr_i,
  input logic [7:0] ctrl_rdata_o,
  input logic       sf_src_i,
  input logic [4:0] sf_code_i,
  input logic [4:0] strap_code_i,
  input logic [4:0] freq_code_o,
  input logic       sys_rst_n_o
);

  p_soft_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rdata_o[4]) |-> $past(ctrl_rdata_o[6]));

  p_hard_drives_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rdata_o[5]) |-> (!sys_rst_n_o && $past(ctrl_rdata_o[7])));

  p_release_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n_o) |-> $past(tick_i));

  p_safe_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata_o[4] |-> (freq_code_o == (sf_src_i ? strap_code_i : sf_code_i)));

  p_restart_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_rdata_o[4]) || $rose(ctrl_rdata_o[5])) |-> $past(!kick_i && !ctrl_wr_i));

  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> (ctrl_rdata_o[5:4] == 2'b00));

endmodule

bind fsafe_wdog fsafe_wdog_chk u_chk (.*);

// File: tb/sim_fsafe_wdog.sv
module sim_fsafe_wdog;

  localparam int CLK_PERIOD = 10;
  localparam int BS = 3;
  localparam int BL = 5;
  localparam int RT = 16;
  localparam logic [4:0] RUN = 5'h0A, SFC = 5'h13, STR = 5'h1C;

  // {ctrl byte, expected ticks to expiry}
  localparam logic [15:0] VEC [8] = '{
    16'h4003, 16'h4309, 16'h4715, 16'h4A0A,
    16'h4805, 16'hC103, 16'h8206, 16'h440C
  };

  logic       clk, rst_n, tick_i, kick_i, ctrl_wr_i, ratio_chg_i, sf_src_i;
  logic [7:0] ctrl_wdata_i, ctrl_rdata_o;
  logic [4:0] freq_code_o;
  logic       sys_rst_n_o;
  int         n_run, n_fail;

  fsafe_wdog #(.BASE_SHORT_TICKS(BS), .BASE_LONG_TICKS(BL), .RST_TICKS(RT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
    .ratio_chg_i(ratio_chg_i), .run_code_i(RUN), .sf_src_i(sf_src_i),
    .sf_code_i(SFC), .strap_code_i(STR), .freq_code_o(freq_code_o),
    .sys_rst_n_o(sys_rst_n_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick1();
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk) begin ctrl_wr_i = 1'b1; ctrl_wdata_i = b; end
    @(negedge clk) ctrl_wr_i = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk) kick_i = 1'b1;
    @(negedge clk) kick_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; tick_i = 0; kick_i = 0; ctrl_wr_i = 0; ctrl_wdata_i = '0;
    ratio_chg_i = 0; sf_src_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10 reset state
    chk(ctrl_rdata_o == 8'h07, "R1 ctrl reset", ctrl_rdata_o, 8'h07);
    chk(sys_rst_n_o == 1'b1, "R1 reset out", sys_rst_n_o, 1);
    chk(freq_code_o == RUN, "R1 freq code", freq_code_o, RUN);

    // R2/R3/R4/R5/R10 vector table
    for (int i = 0; i < 8; i++) begin
      logic [7:0] cb;
      int exp_t, got_t, rel_t;
      cb = VEC[i][15:8];
      exp_t = VEC[i][7:0];
      sf_src_i = i[0];
      wr(cb);
      chk(ctrl_rdata_o == cb, "R10 ctrl readback", ctrl_rdata_o, cb);
      got_t = 0;
      for (int t = 1; t <= 40 && got_t == 0; t++) begin
        tick1();
        if (ctrl_rdata_o[5:4] != 2'b00) got_t = t;
      end
      chk(got_t == exp_t, "R2 ticks to expiry", got_t, exp_t);
      chk(ctrl_rdata_o[5:4] == cb[7:6], "R3 R4 status bits", ctrl_rdata_o[5:4], cb[7:6]);
      chk(freq_code_o == (i[0] ? STR : SFC), "R5 safe code", freq_code_o, i[0] ? STR : SFC);
      chk(sys_rst_n_o == !cb[7], "R3 R4 reset level", sys_rst_n_o, !cb[7]);
      wr(8'h07);
      if (cb[7]) begin
        rel_t = 0;
        for (int t = 1; t <= 20 && rel_t == 0; t++) begin
          tick1();
          if (sys_rst_n_o) rel_t = t;
        end
        chk(rel_t == RT, "R4 reset length", rel_t, RT);
      end
    end

    // R6 kick reloads
    sf_src_i = 1'b0;
    wr(8'h40); ticks(2); kick(); ticks(2);
    chk(ctrl_rdata_o[4] == 1'b0, "R6 kick reload", ctrl_rdata_o[4], 0);
    tick1();
    chk(ctrl_rdata_o[4] == 1'b1, "R6 expiry after kick", ctrl_rdata_o[4], 1);

    // R7 sticky through kick and ticks
    kick(); tick1();
    chk(ctrl_rdata_o[4] == 1'b1, "R7 sticky status", ctrl_rdata_o[4], 1);
    chk(freq_code_o == SFC, "R7 sticky fallback", freq_code_o, SFC);
    // R7 write clears, written status bits ignored
    wr(8'h37);
    chk(ctrl_rdata_o == 8'h07, "R7 write clears", ctrl_rdata_o, 8'h07);
    chk(freq_code_o == RUN, "R7 fallback cleared", freq_code_o, RUN);

    // R6 control write reloads
    wr(8'h40); ticks(2); wr(8'h40); ticks(2);
    chk(ctrl_rdata_o[4] == 1'b0, "R6 write reload", ctrl_rdata_o[4], 0);
    tick1();
    chk(ctrl_rdata_o[4] == 1'b1, "R6 expiry after write", ctrl_rdata_o[4], 1);

    // R9 disabled never expires
    wr(8'h00); ticks(30);
    chk(ctrl_rdata_o == 8'h00, "R9 disabled", ctrl_rdata_o, 8'h00);
    chk(sys_rst_n_o == 1'b1, "R9 no reset", sys_rst_n_o, 1);

    // R8 ratio change pulse
    @(negedge clk) ratio_chg_i = 1'b1;
    @(negedge clk) ratio_chg_i = 1'b0;
    chk(sys_rst_n_o == 1'b0, "R8 reset asserted", sys_rst_n_o, 0);
    ticks(RT - 1);
    chk(sys_rst_n_o == 1'b0, "R8 still low", sys_rst_n_o, 0);
    tick1();
    chk(sys_rst_n_o == 1'b1, "R8 released", sys_rst_n_o, 1);
    chk(freq_code_o == RUN, "R8 code unchanged", freq_code_o, RUN);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule